// File: doc/BRIEF.md
# Settable Clock-Calendar Counter Chain

This block keeps time of day and date as six binary fields: seconds, minutes, hours, day of month, month and year. In run mode it advances the seconds field once for every rising edge of a slow one-second strobe. Each field is compared against its upper limit. When a field is at its limit, the comparator returns that field to its first value and carries into the next field up. The day limit follows the current month, and February also depends on the year.

In setting mode the strobe no longer advances time. A select input names one field, and each cycle with the step input high adds one to that field only. The field wraps inside its own legal range and never carries into its neighbour. A changed month or year can make the current day invalid, and the day is then pulled down to the new month length. The strobe toggles a flash phase. A per-field blink output marks the selected field during the lit half of that phase, so a display stage can flash it once per second.

Top module: `rtc_field_chain`

## Requirements
- R1: While rst_n is low the fields are held at seconds 0, minutes 0, hours 0, day 1, month 1, year 0, and blink is all zero.
- R2: In run mode (set_mode low) the seconds field advances by exactly one in the cycle after a rising edge of tick_1hz. A strobe held high for several cycles advances it only once, and with tick_1hz low no field changes.
- R3: Seconds step from 59 to 0 with a carry into minutes. Minutes step from 59 to 0 with a carry into hours. Otherwise minutes do not change.
- R4: Hours step from 23 to 0 with a carry into the day field.
- R5: The day runs from 1 to the month length and then wraps to 1 with a carry into the month. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when year mod 4 is 0 and 28 days otherwise. All other months have 31 days.
- R6: The month runs 1 to 12, and after 12 it returns to 1 with a carry into the year. The year wraps from YEAR_MAX (default 99) to 0.
- R7: In setting mode (set_mode high) tick edges never change any field. With step low, every field holds.
- R8: field_sel codes are 0 seconds, 1 minutes, 2 hours, 3 day, 4 month and 5 year. Codes 6 and 7 select nothing. In setting mode each cycle with step high adds one to the selected field only. The field wraps within its range (seconds or minutes 59 to 0, hours 23 to 0, day to 1 past the month length, month 12 to 1, year YEAR_MAX to 0) with no carry.
- R9: In setting mode, if a month or year step leaves the day above the new month length, the day becomes that length in the same update.
- R10: blink bit k (bit 0 seconds through bit 5 year) is high only when set_mode is high, field_sel equals k and the flash phase is high. The phase is cleared in run mode and inverts on each tick_1hz rising edge in setting mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-second strobe; rising edges are counted |
| set_mode | input | 1 | High selects setting mode, low selects run mode |
| field_sel | input | 3 | Field picked for stepping and flashing |
| step | input | 1 | Step strobe, one increment per high cycle |
| sec | output | 6 | Seconds 0..59 |
| min | output | 6 | Minutes 0..59 |
| hr | output | 5 | Hours 0..23 |
| day | output | 5 | Day of month 1..31 |
| mon | output | 4 | Month 1..12 |
| yr | output | YEAR_W | Year 0..YEAR_MAX |
| blink | output | 6 | Per-field flash enable |

## Verification
The properties assume that tick_1hz and step are synchronous to clk and change only between edges. They also assume that reset is applied before the first meaningful cycle, so the fields always start from legal values. The stimulus drives every input on the falling clock edge. It holds the strobe high for several cycles to show that only edges count, and it sets up each rollover by stepping fields in setting mode rather than waiting through real time. This keeps every field inside its legal range at all times, which the range properties rely on.

// File: rtl/rtc_field_chain.sv
module rtc_field_chain #(
  parameter int YEAR_W   = 7,
  parameter int YEAR_MAX = 99
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              set_mode,
  input  logic [2:0]        field_sel,
  input  logic              step,
  output logic [5:0]        sec,
  output logic [5:0]        min,
  output logic [4:0]        hr,
  output logic [4:0]        day,
  output logic [3:0]        mon,
  output logic [YEAR_W-1:0] yr,
  output logic [5:0]        blink
);

  localparam logic [YEAR_W-1:0] YTOP = YEAR_W'(YEAR_MAX);

  function automatic logic [4:0] month_len(input logic [3:0] m, input logic [YEAR_W-1:0] y);
    case (m)
      4'd2:                      return (y[1:0] == 2'd0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

  logic tick_q, phase, tick_rise;
  logic c_sec, c_min, c_hr, c_day, c_mon;
  logic [5:0] n_sec, n_min;
  logic [4:0] n_hr, n_day, cur_len, new_len;
  logic [3:0] n_mon;
  logic [YEAR_W-1:0] n_yr;

  assign tick_rise = tick_1hz & ~tick_q;
  assign cur_len   = month_len(mon, yr);

  assign c_sec = sec == 6'd59;
  assign c_min = c_sec & (min == 6'd59);
  assign c_hr  = c_min & (hr == 5'd23);
  assign c_day = c_hr & (day == cur_len);
  assign c_mon = c_day & (mon == 4'd12);

  always_comb begin
    n_sec = sec; n_min = min; n_hr = hr;
    n_day = day; n_mon = mon; n_yr = yr;
    if (!set_mode) begin
      if (tick_rise) begin
        n_sec = c_sec ? 6'd0 : sec + 6'd1;
        if (c_sec) n_min = (min == 6'd59) ? 6'd0 : min + 6'd1;
        if (c_min) n_hr  = (hr == 5'd23) ? 5'd0 : hr + 5'd1;
        if (c_hr)  n_day = (day == cur_len) ? 5'd1 : day + 5'd1;
        if (c_day) n_mon = (mon == 4'd12) ? 4'd1 : mon + 4'd1;
        if (c_mon) n_yr  = (yr == YTOP) ? '0 : yr + 1'b1;
      end
    end else if (step) begin
      case (field_sel)
        3'd0: n_sec = (sec == 6'd59) ? 6'd0 : sec + 6'd1;
        3'd1: n_min = (min == 6'd59) ? 6'd0 : min + 6'd1;
        3'd2: n_hr  = (hr == 5'd23) ? 5'd0 : hr + 5'd1;
        3'd3: n_day = (day >= cur_len) ? 5'd1 : day + 5'd1;
        3'd4: n_mon = (mon == 4'd12) ? 4'd1 : mon + 4'd1;
        3'd5: n_yr  = (yr == YTOP) ? '0 : yr + 1'b1;
        default: ;
      endcase
    end
    new_len = month_len(n_mon, n_yr);
    if (set_mode && n_day > new_len) n_day = new_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= '0; min <= '0; hr <= '0;
      day <= 5'd1; mon <= 4'd1; yr <= '0;
      tick_q <= 1'b0; phase <= 1'b0;
    end else begin
      sec <= n_sec; min <= n_min; hr <= n_hr;
      day <= n_day; mon <= n_mon; yr <= n_yr;
      tick_q <= tick_1hz;
      if (!set_mode)      phase <= 1'b0;
      else if (tick_rise) phase <= ~phase;
    end
  end

  assign blink = (set_mode && phase && field_sel < 3'd6) ? (6'd1 << field_sel) : 6'd0;

endmodule

// File: rtl/rtc_field_chain_chk.sv
module rtc_field_chain_chk #(
  parameter int YEAR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1hz,
  input logic              set_mode,
  input logic [2:0]        field_sel,
  input logic              step,
  input logic [5:0]        sec,
  input logic [5:0]        min,
  input logic [4:0]        hr,
  input logic [4:0]        day,
  input logic [3:0]        mon,
  input logic [YEAR_W-1:0] yr,
  input logic [5:0]        blink
);

  assert_reset_vals_R1: assert property (@(posedge clk)
    !rst_n |=> (sec == 6'd0 && min == 6'd0 && hr == 5'd0 && day == 5'd1 && mon == 4'd1 && yr == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_mode && !tick_1hz) |=> $stable({sec, min, hr, day, mon, yr}));

  assert_sec_min_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sec < 6'd60 && min < 6'd60);

  assert_min_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_mode && sec != 6'd59) |=> $stable(min));

  assert_hr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hr < 5'd24);

  assert_day_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    day >= 5'd1 && day <= 5'd31 && (mon != 4'd2 || day <= 5'd29) &&
    !((mon == 4'd4 || mon == 4'd6 || mon == 4'd9 || mon == 4'd11) && day == 5'd31));

  assert_mon_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mon >= 4'd1 && mon <= 4'd12);

  assert_set_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && !step) |=> $stable({sec, min, hr, day, mon, yr}));

  assert_sec_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && step && field_sel == 3'd0) |=> $stable({min, hr, day, mon, yr}));

  assert_min_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && step && field_sel == 3'd1) |=> $stable({sec, hr, day, mon, yr}));

  assert_blink_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(blink));

  assert_blink_run_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_mode || field_sel > 3'd5) |-> blink == 6'd0);

endmodule

bind rtc_field_chain rtc_field_chain_chk #(.YEAR_W(YEAR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .set_mode(set_mode),
  .field_sel(field_sel), .step(step), .sec(sec), .min(min), .hr(hr),
  .day(day), .mon(mon), .yr(yr), .blink(blink)
);

// File: tb/rtc_field_chain_tb_top.sv
module rtc_field_chain_tb_top;
  localparam int YW = 7;
  localparam int YMAX = 99;

  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, set_mode = 1'b0, step = 1'b0;
  logic [2:0] field_sel = 3'd7;
  logic [5:0] sec, min, blink;
  logic [4:0] hr, day;
  logic [3:0] mon;
  logic [YW-1:0] yr;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  rtc_field_chain #(.YEAR_W(YW), .YEAR_MAX(YMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .set_mode(set_mode),
    .field_sel(field_sel), .step(step), .sec(sec), .min(min), .hr(hr),
    .day(day), .mon(mon), .yr(yr), .blink(blink));

  function automatic int mlen(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  int ms, mm, mh, md, mo, my, ph, tq;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mm = 0; mh = 0; md = 1; mo = 1; my = 0; ph = 0; tq = 0;
    end else begin
      bit rise;
      rise = tick_1hz && !tq;
      tq = tick_1hz;
      if (!set_mode) begin
        ph = 0;
        if (rise) begin
          ms++;
          if (ms == 60) begin ms = 0; mm++; end
          if (mm == 60) begin mm = 0; mh++; end
          if (mh == 24) begin mh = 0; md++; end
          if (md > mlen(mo, my)) begin md = 1; mo++; end
          if (mo == 13) begin mo = 1; my++; end
          if (my > YMAX) my = 0;
        end
      end else begin
        if (rise) ph = 1 - ph;
        if (step) begin
          case (field_sel)
            0: ms = (ms + 1) % 60;
            1: mm = (mm + 1) % 60;
            2: mh = (mh + 1) % 24;
            3: md = (md >= mlen(mo, my)) ? 1 : md + 1;
            4: mo = (mo % 12) + 1;
            5: my = (my + 1) % (YMAX + 1);
            default: ;
          endcase
        end
        if (md > mlen(mo, my)) md = mlen(mo, my);
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      int eb;
      eb = (set_mode && ph == 1 && field_sel < 6) ? (1 << field_sel) : 0;
      chk(tag, "sec", sec, ms); chk(tag, "min", min, mm); chk(tag, "hr", hr, mh);
      chk(tag, "day", day, md); chk(tag, "mon", mon, mo); chk(tag, "yr", yr, my);
      chk(tag, "blink", blink, eb);
    end
  end

  task automatic set_n(int f, int n);
    set_mode = 1'b1; field_sel = 3'(f);
    for (int i = 0; i < n; i++) begin
      step = 1'b1; @(negedge clk);
      step = 1'b0; @(negedge clk);
    end
  endtask

  task automatic pulse_tick();
    tick_1hz = 1'b1; repeat (3) @(negedge clk);
    tick_1hz = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic to_last_second();
    set_n(2, (23 - int'(hr) + 24) % 24);
    set_n(1, (59 - int'(min) + 60) % 60);
    set_n(0, (59 - int'(sec) + 60) % 60);
    set_mode = 1'b0; field_sel = 3'd7; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset day", day, 1); chk("R1", "reset mon", mon, 1);
    chk("R1", "reset sec", sec, 0); chk("R1", "reset blink", blink, 0);
    rst_n = 1'b1; @(negedge clk);

    tag = "R2";
    for (int i = 0; i < 3; i++) pulse_tick();
    chk("R2", "three edges", sec, 3);

    tag = "R5";
    set_n(4, 1); set_n(3, 27);
    to_last_second();
    pulse_tick();
    chk("R5", "leap feb 29", day, 29); chk("R4", "hour wrap", hr, 0);
    chk("R3", "min wrap", min, 0);
    to_last_second();
    pulse_tick();
    chk("R5", "march 1", mon, 3); chk("R5", "day 1", day, 1);

    tag = "R6";
    set_n(4, 9); set_n(3, 30);
    to_last_second();
    pulse_tick();
    chk("R6", "new year mon", mon, 1); chk("R6", "year inc", yr, 1);

    tag = "R8";
    set_n(5, 98);
    chk("R8", "year 99", yr, 99);
    set_n(5, 1);
    chk("R8", "year wrap no carry", yr, 0); chk("R8", "mon untouched", mon, 1);
    set_n(0, 60);
    chk("R8", "sec wrap no carry", min, 0);

    tag = "R9";
    set_n(3, 30);
    set_n(4, 1);
    chk("R9", "clamp leap feb", day, 29);
    set_n(5, 1);
    chk("R9", "clamp plain feb", day, 28);

    tag = "R10";
    set_n(2, 0);
    pulse_tick();
    chk("R10", "blink hours", blink, 6'b000100);
    chk("R7", "tick ignored", sec, 0);
    field_sel = 3'd6; @(negedge clk);
    chk("R10", "no field blink", blink, 0);
    field_sel = 3'd2;
    pulse_tick();
    chk("R10", "blink phase off", blink, 0);

    tag = "R7";
    set_mode = 1'b0; @(negedge clk);
    pulse_tick();
    chk("R7", "run again", sec, 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule